// File: doc/BRIEF.md
# Programmable LCD Raster Timing Generator

This block produces the horizontal and vertical timing for a parallel LCD panel. A host supplies three configuration words. The block divides its source clock down to a pixel clock. It then steps each line through four phases: a sync pulse, a leading wait, the active pixels and a trailing wait. Each frame steps through the same four phases, counted in lines. From these phases it drives the horizontal sync, vertical sync, data-enable and pixel-clock pins, each with a selectable polarity. It also gives one-cycle start-of-frame and end-of-frame markers and the index of the active row.

A start pulse begins a frame. The block then runs frame after frame. A stop pulse lets the current frame finish, after which the block idles and raises a done flag. The block copies all configuration at the start of each frame, so the host may write new values at any time.

In dual-scan mode the programmed line count describes one half of the panel. The block then also reports the matching row of the lower half.

Top module: `lcd_raster_timer`

## Requirements
- R1: The pixel clock period is 2×(D+1) source cycles, where D is `cfg_ctrl_i[7:0]`. Counted from the cycle after a start, the first D+1 cycles of each period are low and the next D+1 are high, before polarity. `cfg_ctrl_i[10]`=1 inverts the pin. While idle the pin rests at its inactive level.
- R2: The line word is encoded as follows. Bits [9:0] hold active pixels−1. Bits [15:10] hold hsync width−1. Bits [23:16] hold trailing wait−1. Bits [31:24] hold leading wait−1. Each line is hsync, then the leading wait, then the active pixels, then the trailing wait, all counted in pixel clocks.
- R3: The frame word is encoded as follows. Bits [9:0] hold active lines−1. Bits [15:10] hold vsync width−1. Bits [23:16] hold the trailing wait as a raw line count. Bits [31:24] hold the leading wait as a raw line count. A wait of zero lines is skipped. A frame is vsync, leading wait, active lines, trailing wait.
- R4: Polarity bits in `cfg_ctrl_i` are: [8] vsync, [9] hsync, [11] data-enable. 0 means active high and 1 means active low. While idle each pin rests at its inactive level.
- R5: Data-enable is active only during the active pixels of active lines.
- R6: `sof_o` is high for one cycle, in the first cycle of vsync of each frame. `eof_o` is high for one cycle, in the first cycle after the last pixel period of the last active line.
- R7: A start pulse while idle begins a frame at its vsync on the next cycle. A start pulse while running has no effect.
- R8: A stop pulse while running lets the current frame complete. The block then idles and `done_o` rises. `done_o` is low after reset and is cleared by the next start.
- R9: Configuration words, polarity and dual mode are copied at each frame start. Changes made during a frame have no effect on that frame.
- R10: During active lines, `row_o` gives the active line index from 0. `row_lo_o` equals `row_o` plus the programmed active line count (active lines−1, plus one) in dual mode, and equals `row_o` otherwise. Outside active lines both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_line_i | input | 32 | Line timing word |
| cfg_frame_i | input | 32 | Frame timing word |
| cfg_ctrl_i | input | 12 | Pixel clock divisor and polarity bits |
| dual_i | input | 1 | Dual-scan mode select |
| start_i | input | 1 | Start pulse |
| stop_i | input | 1 | Stop-at-frame-end pulse |
| pclk_o | output | 1 | Pixel clock pin |
| hsync_o | output | 1 | Horizontal sync pin |
| vsync_o | output | 1 | Vertical sync pin |
| de_o | output | 1 | Data-enable pin |
| sof_o | output | 1 | Start-of-frame pulse |
| eof_o | output | 1 | End-of-frame pulse |
| row_o | output | 10 | Active row index |
| row_lo_o | output | 11 | Matching lower-half row index |
| done_o | output | 1 | Stopped after a stop request |

## Verification
The bench sweeps many small geometries. It predicts every pin in every cycle from the pixel position alone. Zero-line frame waits are included, where a design that failed to skip the empty phase would add a phantom line. A trailing wait of zero also makes `eof_o` coincide with the next frame's `sof_o` or with the stop, which catches a marker emitted one period late.

Stops are placed inside a final frame, with a second frame in some cases. A design that stopped at once, or that forgot the pending stop, would then show truncated frames or no done flag. Mid-frame configuration and polarity rewrites, and a second start during a run, expose designs that use live inputs or restart.

// File: rtl/lcd_timing_pkg.sv
package lcd_timing_pkg;
    localparam int ACT_W     = 10;
    localparam int SYNC_W    = 6;
    localparam int WAIT_W    = 8;
    localparam int DIV_W     = 8;
    localparam int POL_N     = 4;
    localparam int ACT_LSB   = 0;
    localparam int SYNC_LSB  = ACT_LSB + ACT_W;
    localparam int TRAIL_LSB = SYNC_LSB + SYNC_W;
    localparam int LEAD_LSB  = TRAIL_LSB + WAIT_W;
    localparam int WORD_W    = LEAD_LSB + WAIT_W;
    localparam int LEN_W     = ACT_W + 1;
    localparam int CTRL_W    = DIV_W + POL_N;
    localparam int POL_V     = 0;
    localparam int POL_H     = 1;
    localparam int POL_PCLK  = 2;
    localparam int POL_OE    = 3;

    typedef enum logic [1:0] {
        PH_SYNC  = 2'd0,
        PH_LEAD  = 2'd1,
        PH_SHOW  = 2'd2,
        PH_TRAIL = 2'd3
    } phase_e;
endpackage

// File: rtl/lcd_pclk_div.sv
module lcd_pclk_div
    import lcd_timing_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          run_i,
    input  logic [DW-1:0] div_i,
    output logic          tick_o,
    output logic          level_o
);
    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          half;
    } div_t;

    div_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        tick_o  = run_i & (st_q.cnt == div_i) & st_q.half;
        level_o = st_q.half;
        if (clr_i) begin
            st_d.cnt  = '0;
            st_d.half = 1'b0;
        end else if (run_i) begin
            if (st_q.cnt == div_i) begin
                st_d.cnt  = '0;
                st_d.half = ~st_q.half;
            end else begin
                st_d.cnt = st_q.cnt + DW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/lcd_axis_seq.sv
module lcd_axis_seq
    import lcd_timing_pkg::*;
#(
    parameter int CW = ACT_W,
    parameter int LW = LEN_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               step_i,
    input  logic [3:0][LW-1:0] len_i,
    output phase_e             phase_o,
    output logic [CW-1:0]      cnt_o,
    output logic               last_o,
    output logic               wrap_o
);
    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t   st_d, st_q;
    phase_e nxt;
    logic   wraps;

    always_comb begin
        st_d   = st_q;
        nxt    = PH_SYNC;
        wraps  = 1'b0;
        last_o = (LW'(st_q.cnt) == len_i[st_q.ph] - LW'(1));
        case (st_q.ph)
            PH_SYNC: nxt = (len_i[PH_LEAD] != '0) ? PH_LEAD : PH_SHOW;
            PH_LEAD: nxt = PH_SHOW;
            PH_SHOW: begin
                if (len_i[PH_TRAIL] != '0) begin
                    nxt = PH_TRAIL;
                end else begin
                    nxt   = PH_SYNC;
                    wraps = 1'b1;
                end
            end
            default: begin
                nxt   = PH_SYNC;
                wraps = 1'b1;
            end
        endcase
        wrap_o = step_i & last_o & wraps;
        if (clr_i) begin
            st_d.ph  = PH_SYNC;
            st_d.cnt = '0;
        end else if (step_i) begin
            if (last_o) begin
                st_d.ph  = nxt;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    assign phase_o = st_q.ph;
    assign cnt_o   = st_q.cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: PH_SYNC, cnt: '0};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
    import lcd_timing_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] cfg_line_i,
    input  logic [WORD_W-1:0] cfg_frame_i,
    input  logic [CTRL_W-1:0] cfg_ctrl_i,
    input  logic              dual_i,
    input  logic              start_i,
    input  logic              stop_i,
    output logic              pclk_o,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic              sof_o,
    output logic              eof_o,
    output logic [ACT_W-1:0]  row_o,
    output logic [LEN_W-1:0]  row_lo_o,
    output logic              done_o
);
    typedef struct packed {
        logic              run;
        logic              stop_pend;
        logic              done;
        logic              sof;
        logic              eof;
        logic [WORD_W-1:0] line;
        logic [WORD_W-1:0] frame;
        logic [DIV_W-1:0]  div;
        logic [POL_N-1:0]  pol;
        logic              dual;
    } top_t;

    top_t st_d, st_q;

    logic                  start_evt, tick, div_level;
    logic [3:0][LEN_W-1:0] h_len, v_len;
    phase_e                h_ph, v_ph;
    logic [ACT_W-1:0]      h_cnt, v_cnt;
    logic                  h_last, h_wrap, v_last, v_wrap, eof_evt, row_act;
    logic                  run_now;
    logic [WORD_W-1:0]     line_cfg, frame_cfg;
    logic [POL_N-1:0]      pol_cfg;

    assign run_now   = st_q.run;
    assign line_cfg  = st_q.line;
    assign frame_cfg = st_q.frame;
    assign pol_cfg   = st_q.pol;

    // Phase lengths from the frame-start copy: line fields are minus one,
    // frame waits are raw counts.
    always_comb begin
        h_len[PH_SYNC]  = LEN_W'(st_q.line[SYNC_LSB +: SYNC_W]) + LEN_W'(1);
        h_len[PH_LEAD]  = LEN_W'(st_q.line[LEAD_LSB +: WAIT_W]) + LEN_W'(1);
        h_len[PH_SHOW]  = LEN_W'(st_q.line[ACT_LSB +: ACT_W]) + LEN_W'(1);
        h_len[PH_TRAIL] = LEN_W'(st_q.line[TRAIL_LSB +: WAIT_W]) + LEN_W'(1);
        v_len[PH_SYNC]  = LEN_W'(st_q.frame[SYNC_LSB +: SYNC_W]) + LEN_W'(1);
        v_len[PH_LEAD]  = LEN_W'(st_q.frame[LEAD_LSB +: WAIT_W]);
        v_len[PH_SHOW]  = LEN_W'(st_q.frame[ACT_LSB +: ACT_W]) + LEN_W'(1);
        v_len[PH_TRAIL] = LEN_W'(st_q.frame[TRAIL_LSB +: WAIT_W]);
    end

    assign start_evt = start_i & ~st_q.run;

    lcd_pclk_div #(.DW(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (start_evt),
        .run_i   (st_q.run),
        .div_i   (st_q.div),
        .tick_o  (tick),
        .level_o (div_level)
    );

    lcd_axis_seq #(.CW(ACT_W), .LW(LEN_W)) u_hseq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (start_evt),
        .step_i  (tick),
        .len_i   (h_len),
        .phase_o (h_ph),
        .cnt_o   (h_cnt),
        .last_o  (h_last),
        .wrap_o  (h_wrap)
    );

    lcd_axis_seq #(.CW(ACT_W), .LW(LEN_W)) u_vseq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (start_evt),
        .step_i  (h_wrap),
        .len_i   (v_len),
        .phase_o (v_ph),
        .cnt_o   (v_cnt),
        .last_o  (v_last),
        .wrap_o  (v_wrap)
    );

    assign eof_evt = h_wrap & (v_ph == PH_SHOW) & v_last;

    always_comb begin
        st_d     = st_q;
        st_d.sof = 1'b0;
        st_d.eof = eof_evt;
        if (st_q.run && stop_i) st_d.stop_pend = 1'b1;
        if (start_evt || (v_wrap && !(st_q.stop_pend || stop_i))) begin
            st_d.run   = 1'b1;
            st_d.sof   = 1'b1;
            st_d.line  = cfg_line_i;
            st_d.frame = cfg_frame_i;
            st_d.div   = cfg_ctrl_i[DIV_W-1:0];
            st_d.pol   = cfg_ctrl_i[DIV_W +: POL_N];
            st_d.dual  = dual_i;
            if (start_evt) begin
                st_d.done      = 1'b0;
                st_d.stop_pend = 1'b0;
            end
        end else if (v_wrap) begin
            st_d.run       = 1'b0;
            st_d.done      = 1'b1;
            st_d.stop_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign row_act  = st_q.run & (v_ph == PH_SHOW);
    assign pclk_o   = (st_q.run & div_level) ^ st_q.pol[POL_PCLK];
    assign hsync_o  = (st_q.run & (h_ph == PH_SYNC)) ^ st_q.pol[POL_H];
    assign vsync_o  = (st_q.run & (v_ph == PH_SYNC)) ^ st_q.pol[POL_V];
    assign de_o     = (row_act & (h_ph == PH_SHOW)) ^ st_q.pol[POL_OE];
    assign sof_o    = st_q.sof;
    assign eof_o    = st_q.eof;
    assign done_o   = st_q.done;
    assign row_o    = row_act ? v_cnt : '0;
    assign row_lo_o = row_act ? (LEN_W'(v_cnt) + (st_q.dual ? v_len[PH_SHOW] : '0)) : '0;
endmodule

// File: rtl/lcd_raster_chk.sv
module lcd_raster_chk
    import lcd_timing_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              run_i,
    input logic              sof_i,
    input logic              done_i,
    input logic              hsync_i,
    input logic              vsync_i,
    input logic              de_i,
    input logic [POL_N-1:0]  pol_i,
    input logic [WORD_W-1:0] line_i,
    input logic [WORD_W-1:0] frame_i,
    input phase_e            h_ph_i,
    input logic [ACT_W-1:0]  h_cnt_i,
    input logic              h_last_i,
    input logic              tick_i,
    input logic [ACT_W-1:0]  row_i
);
    logic hs_act, vs_act, de_act;
    assign hs_act = hsync_i ^ pol_i[POL_H];
    assign vs_act = vsync_i ^ pol_i[POL_V];
    assign de_act = de_i ^ pol_i[POL_OE];

    AST_SOF_PULSE: assert property (@(posedge clk) disable iff (!rst_n) sof_i |=> !sof_i); // R6
    AST_SOF_VSYNC: assert property (@(posedge clk) disable iff (!rst_n) sof_i |-> vs_act); // R6
    AST_DE_REGION: assert property (@(posedge clk) disable iff (!rst_n) de_act |-> (!hs_act && !vs_act)); // R5
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done_i |-> (!run_i && !de_act)); // R8
    AST_ROW_BOUND: assert property (@(posedge clk) disable iff (!rst_n) row_i <= frame_i[ACT_LSB +: ACT_W]); // R10
    AST_HSYNC_END: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && h_last_i && h_ph_i == PH_SYNC) |=> h_ph_i != PH_SYNC); // R2
    AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !h_last_i) |=> h_cnt_i == $past(h_cnt_i) + ACT_W'(1)); // R2
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sof_i |-> ($stable(line_i) && $stable(frame_i))); // R9
endmodule

bind lcd_raster_timer lcd_raster_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run_now),
    .sof_i    (sof_o),
    .done_i   (done_o),
    .hsync_i  (hsync_o),
    .vsync_i  (vsync_o),
    .de_i     (de_o),
    .pol_i    (pol_cfg),
    .line_i   (line_cfg),
    .frame_i  (frame_cfg),
    .h_ph_i   (h_ph),
    .h_cnt_i  (h_cnt),
    .h_last_i (h_last),
    .tick_i   (tick),
    .row_i    (row_o)
);

// File: tb/sim_lcd_raster_timer.sv
module sim_lcd_raster_timer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cfg_line, cfg_frame;
    logic [11:0] cfg_ctrl;
    logic        dual, start_i, stop_i;
    logic        pclk_o, hsync_o, vsync_o, de_o, sof_o, eof_o, done_o;
    logic [9:0]  row_o;
    logic [10:0] row_lo_o;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  fin = 1'b0;

    always #5 clk = ~clk;

    lcd_raster_timer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_line_i(cfg_line), .cfg_frame_i(cfg_frame),
        .cfg_ctrl_i(cfg_ctrl), .dual_i(dual), .start_i(start_i), .stop_i(stop_i),
        .pclk_o(pclk_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .sof_o(sof_o), .eof_o(eof_o), .row_o(row_o), .row_lo_o(row_lo_o), .done_o(done_o)
    );

    task automatic chk(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic run_case(int pcd, int hsw, int blw, int ppl, int elw,
                            int vsw, int bfw, int lpp, int efw,
                            int pol, int dl, int nfr);
        int p, ht, vt, ft, eo, hb, va0;
        int pv, phz, pp, po;
        p   = 2 * (pcd + 1);
        ht  = (hsw + 1) + (blw + 1) + (ppl + 1) + (elw + 1);
        vt  = (vsw + 1) + bfw + (lpp + 1) + efw;
        ft  = ht * vt * p;
        hb  = (hsw + 1) + (blw + 1);
        va0 = (vsw + 1) + bfw;
        eo  = (va0 + lpp + 1) * ht * p;
        pv  = pol & 1;
        phz = (pol >> 1) & 1;
        pp  = (pol >> 2) & 1;
        po  = (pol >> 3) & 1;
        @(negedge clk);
        cfg_line  = {8'(blw), 8'(elw), 6'(hsw), 10'(ppl)};
        cfg_frame = {8'(bfw), 8'(efw), 6'(vsw), 10'(lpp)};
        cfg_ctrl  = {4'(pol), 8'(pcd)};
        dual      = dl[0];
        start_i   = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int t = 0; t <= nfr * ft + 3; t++) begin
            int e_pclk, e_hs, e_vs, e_de, e_sof, e_eof, e_row, e_rlo, e_done;
            string pre;
            pre = (t > (nfr - 1) * ft + 4) ? "R9 " : ((t > 6) ? "R7 " : "");
            if (t < nfr * ft) begin
                int tt, pix, x, y, la;
                tt     = t % ft;
                pix    = tt / p;
                x      = pix % ht;
                y      = pix / ht;
                la     = (y >= va0 && y < va0 + lpp + 1) ? 1 : 0;
                e_pclk = ((tt % p) >= pcd + 1) ? 1 : 0;
                e_hs   = (x < hsw + 1) ? 1 : 0;
                e_vs   = (y < vsw + 1) ? 1 : 0;
                e_de   = (la == 1 && x >= hb && x < hb + ppl + 1) ? 1 : 0;
                e_row  = la ? (y - va0) : 0;
                e_rlo  = la ? (e_row + (dl ? lpp + 1 : 0)) : 0;
                e_sof  = (tt == 0) ? 1 : 0;
                e_done = 0;
            end else begin
                e_pclk = 0; e_hs = 0; e_vs = 0; e_de = 0;
                e_row = 0; e_rlo = 0; e_sof = 0; e_done = 1;
            end
            e_eof = (t >= eo && ((t - eo) % ft) == 0 && ((t - eo) / ft) < nfr) ? 1 : 0;
            chk({pre, "R1 pclk"},        int'(pclk_o),  e_pclk ^ pp);
            chk({pre, "R2 R4 hsync"},    int'(hsync_o), e_hs ^ phz);
            chk({pre, "R3 R4 vsync"},    int'(vsync_o), e_vs ^ pv);
            chk({pre, "R5 R4 de"},       int'(de_o),    e_de ^ po);
            chk({pre, "R6 sof"},         int'(sof_o),   e_sof);
            chk({pre, "R6 eof"},         int'(eof_o),   e_eof);
            chk({pre, "R10 row"},        int'(row_o),   e_row);
            chk({pre, "R10 row_lo dual"}, int'(row_lo_o), e_rlo);
            chk({pre, "R8 done"},        int'(done_o),  e_done);
            start_i = (t == 6) ? 1'b1 : 1'b0;
            stop_i  = (t == (nfr - 1) * ft + 2) ? 1'b1 : 1'b0;
            if (t == (nfr - 1) * ft + 4) begin
                cfg_line  = 32'h0302_0C05;
                cfg_frame = 32'h0201_0803;
                cfg_ctrl  = ~cfg_ctrl;
                dual      = ~dual;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        for (int c = 0; c < 190000; c++) @(posedge clk);
        if (!fin) begin
            n_bad++;
            $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 190000, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int i;
        rst_n     = 1'b0;
        cfg_line  = '0;
        cfg_frame = '0;
        cfg_ctrl  = '0;
        dual      = 1'b0;
        start_i   = 1'b0;
        stop_i    = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 reset done",   int'(done_o),  0);
        chk("R1 reset pclk",   int'(pclk_o),  0);
        chk("R4 reset hsync",  int'(hsync_o), 0);
        chk("R4 reset vsync",  int'(vsync_o), 0);
        chk("R5 reset de",     int'(de_o),    0);
        chk("R6 reset sof",    int'(sof_o),   0);
        chk("R10 reset row",   int'(row_o),   0);
        i = 0;
        for (int pcd = 0; pcd < 3; pcd++)
            for (int hsw = 0; hsw < 2; hsw++)
                for (int blw = 0; blw < 2; blw++)
                    for (int ppl = 0; ppl < 3; ppl++)
                        for (int elw = 0; elw < 2; elw++) begin
                            run_case(pcd, hsw, blw, ppl, elw,
                                     (i / 5) % 2, i % 3, (i / 2) % 3, (i / 3) % 3,
                                     i % 16, (i / 7) % 2, ((i % 4) == 0) ? 2 : 1);
                            i++;
                        end
        fin = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule